// File: doc/BRIEF.md
# UART Receive DMA Engine

This block moves bytes from a UART receiver into byte-addressed memory without processor involvement. Bytes arrive on a data bus with a one-cycle valid strobe. They are staged in a four-entry receive FIFO and drained into memory through a request/grant write port. Software programs a transfer length, a 16-bit destination address and control bits through a small register port. Software then reads back the number of bytes already stored, a completion flag and a data-loss flag.

The length register holds one less than the number of bytes to move. A start command zeroes the byte count, reloads the working address and latches the length. The engine then accepts bytes while enabled until the programmed amount has been taken in. When the final byte reaches memory, the engine sets the completion flag and returns to idle. An interrupt output follows that flag when interrupts are enabled. If the memory port is starved and the FIFO is full, an arriving byte is discarded and a sticky loss flag records the event.

Register selector map (reg_sel): 0 control, 1 status, 2 length, 3 count (read-only), 4 address high byte, 5 address low byte. Selectors 6 and 7 read as zero.

Top module: `uart_rx_dma`

## Requirements
- R1: After reset, every register reads zero, mem_req is low and irq is low.
- R2: A transfer moves LEN+1 bytes, where LEN is the 8-bit value at selector 2 latched at start. LEN 0 moves one byte and LEN 255 moves 256 bytes.
- R3: The first byte is written at {selector 4, selector 5} as captured at start. Each later byte goes to the previous address plus one, wrapping modulo 2^16.
- R4: A byte is written when mem_req and mem_gnt are both high in the same cycle. While mem_req is high without mem_gnt, mem_req, mem_addr and mem_wdata hold. Bytes reach memory in arrival order.
- R5: Selector 3 reads the low 8 bits of the number of bytes written since the last start. A full 256-byte transfer therefore reads 0.
- R6: Status bit 0 (done) is set by hardware in the cycle of the final write of a transfer. It is cleared only by writing status with bit 0 set, and a hardware set in the same cycle wins.
- R7: irq equals status bit 0 AND control bit 1 (interrupt enable).
- R8: The FIFO holds 4 bytes. A byte that is accepted while 4 bytes are held is dropped and sets status bit 1 (loss). A dropped byte is never written and is not counted.
- R9: The loss flag stays set until status is written with bit 1 set. Clearing done alone leaves it set.
- R10: A byte is ignored, without entering the FIFO and without setting loss, in four cases: control bit 0 (enable) is clear, no start has been issued, the transfer has completed, or LEN+1 bytes have already been accepted.
- R11: Writing control with bit 2 set starts a transfer: the FIFO is flushed, the count is zeroed, the address is reloaded and LEN is latched. Control reads back bits 0 and 1 only, and bit 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel (combinational) |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory grant; a write happens when it is high together with mem_req |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume the bus side obeys the grant convention: a write happens only in a cycle where mem_req and mem_gnt are both high, and mem_gnt may stay low for any number of cycles. Their stability and address-step checks exclude cycles that carry a start command, because a start is allowed to flush pending data. The stimulus drives mem_gnt in three modes: always granted, fully starved to force overflow, and pseudo-random. It changes inputs only just after a rising edge, so the engine always sees settled values and every cycle stays inside those assumptions.

// File: rtl/uart_rx_dma_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the UART receive DMA engine: register selector
// codes, control/status bit positions and the engine state type.
package uart_rx_dma_pkg;
    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd1;
    localparam logic [SEL_W-1:0] SEL_LEN  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CNT  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_AHI  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_ALO  = 3'd5;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_IE   = 1;
    localparam int CTRL_GO   = 2;
    localparam int STAT_DONE = 0;
    localparam int STAT_LOSS = 1;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;
endpackage

// File: rtl/uart_rx_dma_fifo.sv
`timescale 1ns/1ps
// Receive staging FIFO.
// Does: holds up to DEPTH bytes in arrival order; head shows the oldest.
// Assumes: caller never pushes when full nor pops when empty; flush wins
// over push and pop in the same cycle.
module uart_rx_dma_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Advance a pointer with wrap at DEPTH (depth need not be a power of two).
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Store an incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Move the pointers on push, pop and flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
        end
    end

    // Track the number of held bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            level <= '0;
        end else begin
            case ({push, pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));
endmodule

// File: rtl/uart_rx_dma_regs.sv
`timescale 1ns/1ps
// Software-visible register file of the receive DMA engine.
// Does: holds control, length and start address; keeps the sticky done and
// loss flags (write-one-to-clear, hardware set wins); decodes the start
// command; drives the combinational read mux.
// Assumes: set_done / set_loss are single-cycle pulses from the engine.
module uart_rx_dma_regs
    import uart_rx_dma_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = DATA_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                set_done,
    input  logic                set_loss,
    input  logic [CNT_W-1:0]    wr_count,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                enable,
    output logic                irq_en,
    output logic [DATA_W-1:0]   len_cfg,
    output logic [2*DATA_W-1:0] base_addr,
    output logic                start,
    output logic                done_flag,
    output logic                loss_flag
);
    logic [DATA_W-1:0] addr_hi;
    logic [DATA_W-1:0] addr_lo;
    logic              wr_ctrl;
    logic              wr_stat;

    assign wr_ctrl   = reg_we && (reg_sel == SEL_CTRL);
    assign wr_stat   = reg_we && (reg_sel == SEL_STAT);
    assign start     = wr_ctrl && reg_wdata[CTRL_GO];
    assign base_addr = {addr_hi, addr_lo};

    // Control bits: enable and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_ctrl) begin
            enable <= reg_wdata[CTRL_EN];
            irq_en <= reg_wdata[CTRL_IE];
        end
    end

    // Length and start-address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_cfg <= '0;
            addr_hi <= '0;
            addr_lo <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_LEN) len_cfg <= reg_wdata;
            if (reg_sel == SEL_AHI) addr_hi <= reg_wdata;
            if (reg_sel == SEL_ALO) addr_lo <= reg_wdata;
        end
    end

    // Sticky flags: hardware set has priority over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            loss_flag <= 1'b0;
        end else begin
            done_flag <= set_done || (done_flag && !(wr_stat && reg_wdata[STAT_DONE]));
            loss_flag <= set_loss || (loss_flag && !(wr_stat && reg_wdata[STAT_LOSS]));
        end
    end

    // Read mux for the selected register.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CTRL_EN] = enable;
                reg_rdata[CTRL_IE] = irq_en;
            end
            SEL_STAT: begin
                reg_rdata[STAT_DONE] = done_flag;
                reg_rdata[STAT_LOSS] = loss_flag;
            end
            SEL_LEN: reg_rdata = len_cfg;
            SEL_CNT: reg_rdata = DATA_W'(wr_count);
            SEL_AHI: reg_rdata = addr_hi;
            SEL_ALO: reg_rdata = addr_lo;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_dma_engine.sv
`timescale 1ns/1ps
// Transfer sequencer of the receive DMA engine.
// Does: decides per cycle whether an arriving byte is pushed, dropped or
// ignored; issues memory writes from the FIFO head; steps the address and
// the written-byte count; signals completion on the final write.
// Assumes: fifo_full / fifo_empty are registered FIFO state; start flushes
// the FIFO in the same cycle.
module uart_rx_dma_engine
    import uart_rx_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              enable,
    input  logic [LEN_W-1:0]  len_cfg,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              rx_valid,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              mem_gnt,
    output logic              push,
    output logic              drop,
    output logic              pop,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W:0]    wr_cnt,
    output logic [LEN_W-1:0]  len_lat,
    output logic              done_set
);
    localparam int CNT_W = LEN_W + 1;

    eng_state_t        state;
    logic [CNT_W-1:0]  acc_cnt;
    logic [CNT_W-1:0]  xfer_total;
    logic              accepting;
    logic              write;

    assign xfer_total = {1'b0, len_lat} + CNT_W'(1);
    assign accepting  = (state == ENG_RUN) && enable && (acc_cnt != xfer_total);
    assign push       = accepting && rx_valid && !fifo_full;
    assign drop       = accepting && rx_valid && fifo_full;
    assign mem_req    = (state == ENG_RUN) && !fifo_empty;
    assign write      = mem_req && mem_gnt;
    assign pop        = write;
    assign done_set   = write && (wr_cnt == {1'b0, len_lat});

    // Sequencer state, counters and working address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            acc_cnt  <= '0;
            wr_cnt   <= '0;
            mem_addr <= '0;
            len_lat  <= '0;
        end else if (start) begin
            state    <= ENG_RUN;
            acc_cnt  <= '0;
            wr_cnt   <= '0;
            mem_addr <= base_addr;
            len_lat  <= len_cfg;
        end else begin
            if (push) acc_cnt <= acc_cnt + CNT_W'(1);
            if (write) begin
                mem_addr <= mem_addr + ADDR_W'(1);
                wr_cnt   <= wr_cnt + CNT_W'(1);
            end
            if (done_set) state <= ENG_IDLE;
        end
    end
endmodule

// File: rtl/uart_rx_dma.sv
`timescale 1ns/1ps
// UART receive DMA engine, top level.
// Does: ties the register file, sequencer and receive FIFO together and
// drives the memory write port and the completion interrupt.
// Assumes: rx_valid is a single-cycle strobe per byte; the memory side
// completes a write in any cycle where mem_req and mem_gnt are both high.
module uart_rx_dma
    import uart_rx_dma_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_byte,
    input  logic                reg_we,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                mem_req,
    input  logic                mem_gnt,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                irq
);
    localparam int ADDR_W = 2 * DATA_W;
    localparam int LEN_W  = DATA_W;
    localparam int CNT_W  = LEN_W + 1;
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);

    logic              start;
    logic              enable;
    logic              irq_en;
    logic              done_flag;
    logic              loss_flag;
    logic [LEN_W-1:0]  len_cfg;
    logic [LEN_W-1:0]  len_lat;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  wr_cnt;
    logic              push;
    logic              drop;
    logic              pop;
    logic              done_set;
    logic              fifo_empty;
    logic              fifo_full;
    logic [LVL_W-1:0]  fifo_level;

    uart_rx_dma_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .set_done  (done_set),
        .set_loss  (drop),
        .wr_count  (wr_cnt),
        .reg_rdata (reg_rdata),
        .enable    (enable),
        .irq_en    (irq_en),
        .len_cfg   (len_cfg),
        .base_addr (base_addr),
        .start     (start),
        .done_flag (done_flag),
        .loss_flag (loss_flag)
    );

    uart_rx_dma_engine #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .enable     (enable),
        .len_cfg    (len_cfg),
        .base_addr  (base_addr),
        .rx_valid   (rx_valid),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .mem_gnt    (mem_gnt),
        .push       (push),
        .drop       (drop),
        .pop        (pop),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .wr_cnt     (wr_cnt),
        .len_lat    (len_lat),
        .done_set   (done_set)
    );

    uart_rx_dma_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .push      (push),
        .push_data (rx_byte),
        .pop       (pop),
        .head      (mem_wdata),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level     (fifo_level)
    );

    // Interrupt follows the completion flag when enabled.
    assign irq = done_flag && irq_en;
endmodule

// File: rtl/uart_rx_dma_chk.sv
`timescale 1ns/1ps
// Property checker for uart_rx_dma, attached with bind.
// Does: checks write-port handshake, address stepping, flag stickiness,
// FIFO bound and transfer-length bound.
// Assumes: a control write with the start bit may flush pending data, so
// handshake checks skip such cycles.
module uart_rx_dma_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_we,
    input logic [2:0]                 reg_sel,
    input logic [DATA_W-1:0]          reg_wdata,
    input logic                       mem_req,
    input logic                       mem_gnt,
    input logic [2*DATA_W-1:0]        mem_addr,
    input logic [DATA_W-1:0]          mem_wdata,
    input logic                       done_flag,
    input logic                       loss_flag,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input logic [DATA_W:0]            wr_cnt,
    input logic [DATA_W-1:0]          len_lat
);
    logic go_wr;
    logic clr_done;
    logic clr_loss;

    assign go_wr    = reg_we && (reg_sel == 3'd0) && reg_wdata[2];
    assign clr_done = reg_we && (reg_sel == 3'd1) && reg_wdata[0];
    assign clr_loss = reg_we && (reg_sel == 3'd1) && reg_wdata[1];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !go_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !go_wr) |=> (mem_addr == $past(mem_addr) + 1'b1)); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !clr_done) |=> done_flag); // R6

    AST_DONE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(mem_req && mem_gnt)); // R6

    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_flag && !clr_loss) |=> loss_flag); // R9

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH)); // R8

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= ({1'b0, len_lat} + 1'b1)); // R2
endmodule

bind uart_rx_dma uart_rx_dma_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (FIFO_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .done_flag  (done_flag),
    .loss_flag  (loss_flag),
    .fifo_level (fifo_level),
    .wr_cnt     (wr_cnt),
    .len_lat    (len_lat)
);

// File: tb/uart_rx_dma_bench.sv
`timescale 1ns/1ps
// Bench for uart_rx_dma: behavioural reference model compared every clock,
// plus directed register checks at scenario boundaries.
module uart_rx_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int gmode  = 0;
    int idle_sel = 0;
    bit finished = 1'b0;

    // Reference model state.
    logic [7:0]  q[$];
    bit          m_run, m_en, m_ie, m_done, m_loss;
    int          m_acc, m_wr, m_len_l;
    logic [7:0]  m_len_r, m_ahi, m_alo;
    logic [15:0] m_addr;

    uart_rx_dma u_uart_rx_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_gnt   (mem_gnt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] s);
        case (s)
            3'd0:    return {6'b0, m_ie, m_en};
            3'd1:    return {6'b0, m_loss, m_done};
            3'd2:    return m_len_r;
            3'd3:    return m_wr[7:0];
            3'd4:    return m_ahi;
            3'd5:    return m_alo;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] s);
        case (s)
            3'd0:    return "R11 ctrl";
            3'd1:    return "R6 status";
            3'd2:    return "R2 len";
            3'd3:    return "R5 count";
            default: return "R3 addr/unused";
        endcase
    endfunction

    // Reference model: advance one clock from the inputs of this cycle.
    always @(posedge clk) begin : model
        bit st, wr, last, acc, pu, dr;
        if (!rst_n) begin
            q.delete();
            m_run = 0; m_en = 0; m_ie = 0; m_done = 0; m_loss = 0;
            m_acc = 0; m_wr = 0; m_len_l = 0;
            m_len_r = 0; m_ahi = 0; m_alo = 0; m_addr = 0;
        end else begin
            st   = reg_we && reg_sel == 3'd0 && reg_wdata[2];
            acc  = m_run && m_en && (m_acc != m_len_l + 1);
            pu   = acc && rx_valid && (q.size() < 4);
            dr   = acc && rx_valid && (q.size() >= 4);
            wr   = m_run && (q.size() > 0) && mem_gnt;
            last = wr && (m_wr + 1 == m_len_l + 1);
            if (reg_we) begin
                case (reg_sel)
                    3'd0: begin m_en = reg_wdata[0]; m_ie = reg_wdata[1]; end
                    3'd1: begin
                        if (reg_wdata[0]) m_done = 0;
                        if (reg_wdata[1]) m_loss = 0;
                    end
                    3'd2: m_len_r = reg_wdata;
                    3'd4: m_ahi = reg_wdata;
                    3'd5: m_alo = reg_wdata;
                    default: ;
                endcase
            end
            if (last) m_done = 1;
            if (dr)   m_loss = 1;
            if (wr) begin
                void'(q.pop_front());
                m_addr = m_addr + 16'd1;
                m_wr++;
            end
            if (pu) begin
                q.push_back(rx_byte);
                m_acc++;
            end
            if (last) m_run = 0;
            if (st) begin
                q.delete();
                m_run = 1; m_acc = 0; m_wr = 0;
                m_addr = {m_ahi, m_alo};
                m_len_l = int'(m_len_r);
            end
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(16'(mem_req), 16'(m_run && q.size() > 0), "R4 mem_req");
            if (mem_req && m_run && q.size() > 0) begin
                chk(mem_addr, m_addr, "R3 mem_addr");
                chk(16'(mem_wdata), 16'(q[0]), "R4 mem_wdata order");
            end
            chk(16'(irq), 16'(m_done && m_ie), "R7 irq");
            chk(16'(reg_rdata), 16'(exp_rd(reg_sel)), rd_tag(reg_sel));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic bit gnt_pick();
        case (gmode)
            0:       return 1'b1;
            1:       return 1'b0;
            default: return ($urandom_range(2) != 0);
        endcase
    endfunction

    task automatic cyc(input bit v, input logic [7:0] b, input bit we,
                       input logic [2:0] sel, input logic [7:0] wd);
        @(posedge clk); #1;
        rx_valid  = v;
        rx_byte   = b;
        reg_we    = we;
        reg_sel   = sel;
        reg_wdata = wd;
        mem_gnt   = gnt_pick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            idle_sel = (idle_sel + 1) % 8;
            cyc(0, 8'h00, 0, 3'(idle_sel), 8'h00);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
        cyc(0, 8'h00, 1, sel, val);
    endtask

    task automatic send(input logic [7:0] b);
        idle_sel = (idle_sel + 1) % 8;
        cyc(1, b, 0, 3'(idle_sel), 8'h00);
    endtask

    task automatic rd_expect(input logic [2:0] sel, input logic [7:0] exp, input string tag);
        cyc(0, 8'h00, 0, sel, 8'h00);
        @(negedge clk); #1;
        chk(16'(reg_rdata), 16'(exp), tag);
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int s = 0; s < 8; s++) rd_expect(3'(s), 8'h00, "R1 reset register");
        chk(16'(mem_req), 16'd0, "R1 reset mem_req");
        chk(16'(irq), 16'd0, "R1 reset irq");

        // R10: bytes before any start are ignored
        wr_reg(3'd0, 8'h03);
        send(8'h55); send(8'h56);
        idle(3);
        rd_expect(3'd1, 8'h00, "R10 no loss before start");
        rd_expect(3'd3, 8'h00, "R10 count before start");

        // Basic transfer: 4 bytes at 0x1234
        gmode = 0;
        wr_reg(3'd4, 8'h12); wr_reg(3'd5, 8'h34); wr_reg(3'd2, 8'd3);
        wr_reg(3'd0, 8'h07);
        rd_expect(3'd0, 8'h03, "R11 start bit reads 0");
        for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i));
        idle(4);
        rd_expect(3'd3, 8'd4, "R5 count after 4 bytes");
        rd_expect(3'd1, 8'h01, "R6 done set");
        chk(16'(irq), 16'd1, "R7 irq with enable");

        // R10: bytes after completion ignored
        send(8'h11); send(8'h12); send(8'h13);
        idle(3);
        rd_expect(3'd3, 8'd4, "R10 count after complete");
        rd_expect(3'd1, 8'h01, "R10 no loss after complete");

        wr_reg(3'd1, 8'h01);
        rd_expect(3'd1, 8'h00, "R6 done cleared by write");
        chk(16'(irq), 16'd0, "R7 irq low after clear");

        // R3: address wrap with random grants
        gmode = 2;
        wr_reg(3'd4, 8'hFF); wr_reg(3'd5, 8'hFE); wr_reg(3'd2, 8'd5);
        wr_reg(3'd0, 8'h07);
        for (int i = 0; i < 6; i++) begin send(8'hC0 + 8'(i)); idle(1); end
        idle(20);
        wr_reg(3'd1, 8'h03);

        // R8/R9: starved memory, overflow
        gmode = 1;
        wr_reg(3'd4, 8'h40); wr_reg(3'd5, 8'h00); wr_reg(3'd2, 8'd9);
        wr_reg(3'd0, 8'h05);
        for (int i = 0; i < 6; i++) send(8'h60 + 8'(i));
        rd_expect(3'd1, 8'h02, "R8 loss set on full FIFO");
        rd_expect(3'd3, 8'd0, "R8 nothing written while starved");
        gmode = 0;
        idle(6);
        rd_expect(3'd3, 8'd4, "R8 only 4 bytes kept");
        for (int i = 0; i < 6; i++) send(8'h70 + 8'(i));
        idle(6);
        rd_expect(3'd1, 8'h03, "R9 loss still set at done");
        chk(16'(irq), 16'd0, "R7 irq masked");
        wr_reg(3'd1, 8'h01);
        rd_expect(3'd1, 8'h02, "R9 loss survives done clear");
        wr_reg(3'd1, 8'h02);
        rd_expect(3'd1, 8'h00, "R9 loss cleared by write");

        // R10: disabled engine ignores bytes; R11 restart
        wr_reg(3'd0, 8'h04);
        send(8'h21); send(8'h22); send(8'h23);
        idle(3);
        rd_expect(3'd3, 8'd0, "R10 disabled ignores bytes");
        rd_expect(3'd1, 8'h00, "R10 disabled no loss");
        wr_reg(3'd0, 8'h01);
        send(8'h24); send(8'h25);
        idle(4);
        rd_expect(3'd3, 8'd2, "R10 accepted once enabled");
        gmode = 1;
        send(8'h26); send(8'h27); send(8'h28);
        wr_reg(3'd0, 8'h05);
        gmode = 0;
        idle(3);
        rd_expect(3'd3, 8'd0, "R11 restart zeroes count and flushes");

        // R2: LEN 0 moves one byte
        wr_reg(3'd2, 8'd0); wr_reg(3'd4, 8'h00); wr_reg(3'd5, 8'h10);
        wr_reg(3'd0, 8'h07);
        send(8'h91); send(8'h92);
        idle(4);
        rd_expect(3'd3, 8'd1, "R2 LEN 0 gives one byte");
        rd_expect(3'd1, 8'h01, "R2 LEN 0 completes");
        wr_reg(3'd1, 8'h03);

        // R2: LEN 255 moves 256 bytes; count reads 0
        wr_reg(3'd2, 8'd255); wr_reg(3'd4, 8'h80); wr_reg(3'd5, 8'h00);
        wr_reg(3'd0, 8'h07);
        for (int i = 0; i < 256; i++) send(8'(i));
        idle(4);
        rd_expect(3'd3, 8'd0, "R2 256 bytes count wraps");
        rd_expect(3'd1, 8'h01, "R2 LEN 255 completes");
        wr_reg(3'd1, 8'h03);

        // Soak: random lengths, spacing and grants against the model
        gmode = 2;
        for (int r = 0; r < 6; r++) begin
            wr_reg(3'd2, 8'($urandom_range(20)));
            wr_reg(3'd4, 8'($urandom_range(255)));
            wr_reg(3'd5, 8'($urandom_range(255)));
            wr_reg(3'd0, 8'h07);
            for (int i = 0; i < 30; i++) begin
                if ($urandom_range(1) == 1) send(8'($urandom_range(255)));
                else idle(1);
            end
            idle(20);
            wr_reg(3'd1, 8'h03);
        end

        idle(4);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule